// File: doc/BRIEF.md
# Dual-Compare Programmable Pulse Generator

This block shapes a repeating pulse on one output from a free-running up-counter and two compare points. One compare value, A, marks where the output falls. The other, B, marks where it rises. A match never resets the counter, so the period is always the full counter range, measured in count-enable ticks. The duty cycle and phase come from where A and B sit in that range.

Software loads the compare values and a small control word through one register write port. Compare writes land in buffer registers. While the generator is stopped, the active compare registers follow the buffers. While it runs, they take the buffered values only on the tick that wraps the counter from its top value back to zero, so a period is never cut in half by a rewrite. A match can also raise a one-cycle interrupt request if the control word enables it. A prescaled count-enable input paces the counter.

Top module: `ppg_dual_cmp`

## Requirements
- R1: While running, the counter advances by one only on clock cycles where `cnt_tick` is high. On other cycles it holds its value.
- R2: When the count on a tick equals active compare A, and not B, `pulse_out` is low from the next cycle on.
- R3: When the count on a tick equals active compare B, `pulse_out` is high from the next cycle on.
- R4: When A and B hold the same value, the B match takes priority, and `pulse_out` goes high at that count.
- R5: A compare match does not clear the counter. After the count reaches its all-ones value, the next tick takes it to zero, and the pattern repeats every 2^CNT_W ticks.
- R6: Writes with `wr_sel`=0 (A) or `wr_sel`=1 (B) go to buffer registers. While running, the active compare values change only on the tick where the count is all-ones, and they take the buffer contents from before that edge. A rewrite in the middle of a period does not affect the rest of that period.
- R7: After reset, and while the run bit is clear, the counter sits at zero, `pulse_out` is low and `match_irq` is low. While stopped, the active compare values track the buffers, so values loaded before the run bit is set take effect from count zero.
- R8: `match_irq` is high for exactly the one cycle after a tick on which the count equals A or B. This happens only if the interrupt-enable bit is set. Otherwise it stays low.
- R9: A write with `wr_sel`=2 loads the control word: `wr_data[0]` is the run bit and `wr_data[1]` is the interrupt enable. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 compare A buffer, 1 compare B buffer, 2 control, 3 none |
| wr_data | input | CNT_W | Write data |
| cnt_tick | input | 1 | Prescaled count enable |
| pulse_out | output | 1 | Shaped pulse |
| match_irq | output | 1 | One-cycle match interrupt request |

## Verification
The main check is a sweep over every pair of A and B for a 4-bit counter, with a tick on every cycle over more than two periods. This separates A-before-B, B-before-A, equal values and values at zero and at the top count. A second pattern gates the tick irregularly, which shows whether the counter and output honour the enable. Mid-period buffer rewrites, where one value lands before its old match and one after, show whether the active values are held until the wrap. Stopping while the output is high, running with the interrupt disabled, and writes to the unused select show idle and masking behaviour at the output pins.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef enum logic [1:0] {
    SEL_CMP_A = 2'd0,
    SEL_CMP_B = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IRQ_BIT = 1;

  // Output level after one count step: B match has priority over A.
  function automatic logic next_level(input logic cur, input logic tick,
                                      input logic hit_a, input logic hit_b);
    logic lvl;
    lvl = cur;
    if (tick) begin
      if (hit_b)      lvl = 1'b1;
      else if (hit_a) lvl = 1'b0;
    end
    return lvl;
  endfunction

  // Interrupt request for one count step.
  function automatic logic match_req(input logic tick, input logic irq_en,
                                     input logic hit_a, input logic hit_b);
    return tick && irq_en && (hit_a || hit_b);
  endfunction

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap_i,
  output logic             run_o,
  output logic             irq_en_o,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o
);

  logic [CNT_W-1:0] buf_a_q, buf_b_q;
  logic [CNT_W-1:0] act_a_q, act_b_q;
  logic             run_q, irq_en_q;
  logic             load_active;

  assign load_active = !run_q || wrap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a_q  <= '0;
      buf_b_q  <= '0;
      act_a_q  <= '0;
      act_b_q  <= '0;
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel_e'(wr_sel))
          SEL_CMP_A: buf_a_q <= wr_data;
          SEL_CMP_B: buf_b_q <= wr_data;
          SEL_CTRL: begin
            run_q    <= wr_data[CTRL_RUN_BIT];
            irq_en_q <= wr_data[CTRL_IRQ_BIT];
          end
          default: ;
        endcase
      end
      if (load_active) begin
        act_a_q <= buf_a_q;
        act_b_q <= buf_b_q;
      end
    end
  end

  assign run_o    = run_q;
  assign irq_en_o = irq_en_q;
  assign cmp_a_o  = act_a_q;
  assign cmp_b_o  = act_b_q;

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap_i) |=> ($stable(act_a_q) && $stable(act_b_q))); // R6

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i && tick_i && (cnt_q == CNT_MAX);

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(cnt_q)); // R1

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/ppg_shaper.sv
module ppg_shaper
  import ppg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic irq_en_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic pulse_o,
  output logic irq_o
);

  logic pulse_q, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!run_i) begin
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pulse_q <= next_level(pulse_q, tick_i, hit_a_i, hit_b_i);
      irq_q   <= match_req(tick_i, irq_en_i, hit_a_i, hit_b_i);
    end
  end

  assign pulse_o = pulse_q;
  assign irq_o   = irq_q;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(run_i && tick_i && irq_en_i && (hit_a_i || hit_b_i))); // R8

endmodule

// File: rtl/ppg_dual_cmp.sv
module ppg_dual_cmp
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_tick,
  output logic             pulse_out,
  output logic             match_irq
);

  logic             run, irq_en, wrap;
  logic [CNT_W-1:0] cmp_a, cmp_b, cnt;
  logic             hit_a, hit_b;

  ppg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wrap_i   (wrap),
    .run_o    (run),
    .irq_en_o (irq_en),
    .cmp_a_o  (cmp_a),
    .cmp_b_o  (cmp_b)
  );

  ppg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_i (cnt_tick),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  assign hit_a = (cnt == cmp_a);
  assign hit_b = (cnt == cmp_b);

  ppg_shaper u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .tick_i   (cnt_tick),
    .irq_en_i (irq_en),
    .hit_a_i  (hit_a),
    .hit_b_i  (hit_b),
    .pulse_o  (pulse_out),
    .irq_o    (match_irq)
  );

  AST_B_SETS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_tick && hit_b) |=> pulse_out); // R3

  AST_A_SETS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_tick && hit_a && !hit_b) |=> !pulse_out); // R2

  AST_NO_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_tick && (hit_a || hit_b) && !wrap) |=> (cnt != '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pulse_out && !match_irq && cnt == '0)); // R7

endmodule

// File: tb/ppg_dual_cmp_bench.sv
module ppg_dual_cmp_bench;

  localparam int W = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         cnt_tick = 1'b0;
  logic         pulse_out, match_irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [W-1:0] m_bufa = '0, m_bufb = '0, m_acta = '0, m_actb = '0, m_cnt = '0;
  logic         m_run = 1'b0, m_ie = 1'b0, m_out = 1'b0, m_irq = 1'b0;
  string        out_tag = "R7";

  always #4 clk = ~clk;

  ppg_dual_cmp #(.CNT_W(W)) u_ppg_dual_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_tick(cnt_tick),
    .pulse_out(pulse_out), .match_irq(match_irq)
  );

  task automatic check_outputs(input string phase);
    checks++;
    if (pulse_out !== m_out) begin
      errors++;
      $display("FAIL %s/%s pulse_out actual %0b expected %0b", out_tag, phase, pulse_out, m_out);
    end
    checks++;
    if (match_irq !== m_irq) begin
      errors++;
      $display("FAIL R8/%s match_irq actual %0b expected %0b", phase, match_irq, m_irq);
    end
  endtask

  // One clock: drive at the falling edge, update the reference, compare at the next falling edge.
  task automatic step(input logic we, input logic [1:0] sel, input logic [W-1:0] d,
                      input logic tk, input string phase);
    logic ha, hb, wrp;
    logic [W-1:0] na, nb;
    wr_en = we; wr_sel = sel; wr_data = d; cnt_tick = tk;
    ha  = (m_cnt == m_acta);
    hb  = (m_cnt == m_actb);
    wrp = m_run && tk && (m_cnt == TOP);
    if (!m_run)          out_tag = "R7";
    else if (tk && hb)   out_tag = ha ? "R4" : "R3";
    else if (tk && ha)   out_tag = "R2";
    else if (!tk)        out_tag = "R1";
    else                 out_tag = "R5";
    na = m_acta; nb = m_actb;
    if (!m_run || wrp) begin na = m_bufa; nb = m_bufb; end
    if (!m_run) begin
      m_out = 1'b0; m_irq = 1'b0;
    end else begin
      m_irq = tk && m_ie && (ha || hb);
      if (tk && hb)      m_out = 1'b1;
      else if (tk && ha) m_out = 1'b0;
    end
    if (!m_run)  m_cnt = '0;
    else if (tk) m_cnt = m_cnt + 1'b1;
    m_acta = na; m_actb = nb;
    if (we) begin
      case (sel)
        2'd0: m_bufa = d;
        2'd1: m_bufb = d;
        2'd2: begin m_run = d[0]; m_ie = d[1]; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs(phase);
  endtask

  task automatic setup(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] ctrl, input string phase);
    step(1'b1, 2'd2, '0, 1'b1, phase);
    step(1'b1, 2'd0, a, 1'b1, phase);
    step(1'b1, 2'd1, b, 1'b1, phase);
    step(1'b1, 2'd2, ctrl, 1'b1, phase);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R7 reset");

    // R9: unused select must not start the generator or load values
    step(1'b1, 2'd3, 4'hF, 1'b1, "R9");
    repeat (20) step(1'b0, 2'd0, '0, 1'b1, "R9");
    setup(4'd2, 4'd5, 4'd3, "R9");
    step(1'b1, 2'd3, 4'd0, 1'b1, "R9");
    repeat (40) step(1'b0, 2'd0, '0, 1'b1, "R9");

    // R1: irregular tick gating
    setup(4'd3, 4'd11, 4'd3, "R1");
    for (int i = 0; i < 120; i++)
      step(1'b0, 2'd0, '0, ((i % 3) == 0) || ((i % 7) == 5), "R1");

    // R6: rewrite buffers mid-period
    setup(4'd3, 4'd9, 4'd3, "R6");
    while (m_cnt != 4'd6) step(1'b0, 2'd0, '0, 1'b1, "R6");
    step(1'b1, 2'd1, 4'd12, 1'b1, "R6");
    step(1'b1, 2'd0, 4'd1, 1'b1, "R6");
    repeat (40) step(1'b0, 2'd0, '0, 1'b1, "R6");
    while (m_cnt != TOP) step(1'b0, 2'd0, '0, 1'b1, "R6");
    step(1'b1, 2'd0, 4'd7, 1'b1, "R6");
    repeat (36) step(1'b0, 2'd0, '0, 1'b1, "R6");

    // R8: interrupt masked
    setup(4'd4, 4'd8, 4'd1, "R8");
    repeat (36) step(1'b0, 2'd0, '0, 1'b1, "R8");

    // R7: stop while output high, then restart
    setup(4'd12, 4'd2, 4'd3, "R7");
    while (!m_out) step(1'b0, 2'd0, '0, 1'b1, "R7");
    step(1'b1, 2'd2, 4'd0, 1'b1, "R7");
    repeat (5) step(1'b0, 2'd0, '0, 1'b1, "R7");
    step(1'b1, 2'd2, 4'd3, 1'b1, "R7");
    repeat (20) step(1'b0, 2'd0, '0, 1'b1, "R7");

    // R5 / R2 / R3 / R4: every compare pair over two periods
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        setup(a[W-1:0], b[W-1:0], 4'd3, "R5");
        repeat (35) step(1'b0, 2'd0, '0, 1'b1, "R5");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule